// File: doc/BRIEF.md
# Serial Frequency-Control Word Receiver

This block receives a 16-bit frequency-control word over a three-wire, write-only serial link. The link has an active-low select, a serial clock and a data line. The host lowers select and presents data most significant bit first, one bit on each rising serial-clock edge. The receiver does not wait for the end of the frame. Each time eight bits have arrived, it writes them straight into the matching byte of the control word. A host that only needs to change the octave and the upper part of the DAC code can therefore send a single byte and raise select.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and serial-clock rising edges are found by comparing successive synchronized samples. The stored word is split into three registered output fields: a 4-bit octave code, a 10-bit DAC code and a 2-bit output-configuration code. A one-cycle strobe marks every byte write.

Top module: `spi_freq_ctl_rx`

## Requirements
- R1: After a synchronous reset the octave, DAC and configuration outputs are all zero and the update strobe is low.
- R2: Bits are taken most significant first. The first eight bits of a transaction are written to word bits 15..8 on the eighth rising serial-clock edge.
- R3: Bits nine to sixteen of a transaction are written to word bits 7..0 on the sixteenth rising serial-clock edge.
- R4: A transaction that ends after eight bits changes word bits 15..8 only; bits 7..0 keep their previous value.
- R5: The octave output is word bits 15..12, the DAC output is word bits 11..2 and the configuration output is word bits 1..0.
- R6: Raising select discards a byte that is only partly received and leaves its lane unchanged. The next transaction starts again at word bits 15..8.
- R7: Serial-clock edges while select is high change neither the word nor the strobe.
- R8: The update strobe is high for exactly one system-clock cycle for each byte written, in the same cycle that the new value first appears on the outputs.
- R9: Bits after the sixteenth in one transaction are ignored.
- R10: A byte appears on the outputs after the third rising system-clock edge that follows the serial-clock rising edge completing it. This assumes the pin changes between system-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, asynchronous, data taken on rising edge |
| spi_sdi | input | 1 | Serial data, most significant bit first |
| spi_cs_n | input | 1 | Active-low transaction select |
| oct_o | output | 4 | Octave code, word bits 15..12 |
| dac_o | output | 10 | DAC code, word bits 11..2 |
| cnf_o | output | 2 | Output-configuration code, word bits 1..0 |
| upd_o | output | 1 | One-cycle pulse on each byte write |

## Verification
Every result is due on the third system-clock edge after the serial-clock rising edge that completes a byte. That is two synchronizer stages followed by the register write. The strobe is due on that same edge. The bench drives pins on falling system-clock edges and runs a behavioural model that delays the pins by the same two stages. Every field and the strobe are compared against that model on each falling edge. Directed checks on whole frames are taken only after the link has been idle for several cycles. One sequence counts the edges one by one to confirm that the old value holds for two edges and the new value and strobe arrive on the third.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int unsigned DEF_WORD_W  = 16;
  localparam int unsigned DEF_BYTE_W  = 8;
  localparam int unsigned DEF_OCT_W   = 4;
  localparam int unsigned DEF_DAC_W   = 10;
  localparam int unsigned DEF_CNF_W   = 2;
  localparam int unsigned DEF_SYNC_N  = 2;

  // Lane number (0 = least significant byte) for the n-th byte of a frame.
  function automatic int unsigned lane_of(input int unsigned idx, input int unsigned nbytes);
    return nbytes - 1 - idx;
  endfunction
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/frx_shifter.sv
module frx_shifter #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned BIT_CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1,
  localparam int unsigned IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic              sck_q;
  logic [BIT_CW-1:0] bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shnext;
  logic              rise;
  logic              take;
  logic              last_bit;

  assign rise     = sck_s & ~sck_q & ~csn_s;
  assign take     = rise && (byte_idx < IDX_W'(NBYTES));
  assign last_bit = (bit_cnt == BIT_CW'(BYTE_W - 1));
  assign shnext   = {shreg[BYTE_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
    end else if (take) begin
      shreg <= shnext;
      if (last_bit) begin
        bit_cnt  <= '0;
        byte_idx <= byte_idx + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign done_o = take && last_bit;
  assign idx_o  = byte_idx;
  assign byte_o = shnext;

  // R6: a high select leaves the receiver at the start of the upper byte
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (bit_cnt == '0 && byte_idx == '0));
  // R9: the byte index never runs past the end of the word
  a_r9_index_capped: assert property (@(posedge clk) disable iff (rst)
    byte_idx <= IDX_W'(NBYTES));
  // R9: once the word is full, no further byte is handed on
  a_r9_no_extra_byte: assert property (@(posedge clk) disable iff (rst)
    (byte_idx == IDX_W'(NBYTES)) |-> !done_o);
endmodule

// File: rtl/frx_regfile.sv
module frx_regfile #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned WORD_W = BYTE_W * NBYTES,
  localparam int unsigned IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o
);
  logic [WORD_W-1:0] word_q;
  logic              upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= wr_i;
      for (int l = 0; l < int'(NBYTES); l++) begin
        if (wr_i && (idx_i == IDX_W'(frx_pkg::lane_of(l, NBYTES))))
          word_q[l*BYTE_W +: BYTE_W] <= byte_i;
      end
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;

  // R8: the strobe never lasts two cycles
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> !upd_q);
  // R4: writing the first byte leaves the lower bits alone
  a_r4_low_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_i && idx_i == '0) |=> $stable(word_q[WORD_W-BYTE_W-1:0]));
endmodule

// File: rtl/spi_freq_ctl_rx.sv
module spi_freq_ctl_rx #(
  parameter int unsigned BYTE_W  = frx_pkg::DEF_BYTE_W,
  parameter int unsigned NBYTES  = frx_pkg::DEF_WORD_W / frx_pkg::DEF_BYTE_W,
  parameter int unsigned OCT_W   = frx_pkg::DEF_OCT_W,
  parameter int unsigned DAC_W   = frx_pkg::DEF_DAC_W,
  parameter int unsigned CNF_W   = frx_pkg::DEF_CNF_W,
  parameter int unsigned SYNC_N  = frx_pkg::DEF_SYNC_N,
  localparam int unsigned WORD_W = BYTE_W * NBYTES,
  localparam int unsigned IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_sdi,
  input  logic             spi_cs_n,
  output logic [OCT_W-1:0] oct_o,
  output logic [DAC_W-1:0] dac_o,
  output logic [CNF_W-1:0] cnf_o,
  output logic             upd_o
);
  logic [2:0]        pins_s;
  logic              sck_s, sdi_s, csn_s;
  logic              done;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rx_byte;
  logic [WORD_W-1:0] word;

  frx_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({spi_cs_n, spi_sck, spi_sdi}),
    .q_o(pins_s)
  );
  assign csn_s = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  frx_shifter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_shift (
    .clk(clk), .rst(rst),
    .sck_s(sck_s), .sdi_s(sdi_s), .csn_s(csn_s),
    .done_o(done), .idx_o(idx), .byte_o(rx_byte)
  );

  frx_regfile #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_i(done), .idx_i(idx), .byte_i(rx_byte),
    .word_o(word), .upd_o(upd_o)
  );

  // R5: field placement inside the stored word
  assign oct_o = word[WORD_W-1 -: OCT_W];
  assign dac_o = word[CNF_W +: DAC_W];
  assign cnf_o = word[CNF_W-1:0];

  // R7: while the synchronized select is high the word does not move
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(word));
  // R8: a strobe always accompanies a change or rewrite, never appears idle
  a_r8_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !upd_o);
endmodule

// File: tb/sim_spi_freq_ctl_rx.sv
module sim_spi_freq_ctl_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic [3:0] oct;
  logic [9:0] dac;
  logic [1:0] cnf;
  logic upd;

  localparam int HP = 4;

  spi_freq_ctl_rx u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_sdi(sdi), .spi_cs_n(cs_n),
    .oct_o(oct), .dac_o(dac), .cnf_o(cnf), .upd_o(upd)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference: pins delayed two cycles, bits collected per frame.
  logic m_c1, m_c2, m_k1, m_k2, m_d1, m_d2, m_kq;
  logic [15:0] m_word, m_acc;
  logic m_upd;
  int   m_nbits;
  bit   m_ok = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_word = '0; m_acc = '0; m_upd = 0; m_nbits = 0;
      m_c1 = 1; m_c2 = 1; m_k1 = 0; m_k2 = 0; m_d1 = 0; m_d2 = 0; m_kq = 0;
      m_ok = 1;
    end else begin
      m_upd = 0;
      if (m_c2) m_nbits = 0;
      else if (m_k2 && !m_kq && m_nbits < 16) begin
        m_acc = {m_acc[14:0], m_d2};
        m_nbits++;
        if (m_nbits == 8)  begin m_word[15:8] = m_acc[7:0]; m_upd = 1; end
        if (m_nbits == 16) begin m_word[7:0]  = m_acc[7:0]; m_upd = 1; end
      end
      m_kq = m_k2;
      m_c2 = m_c1; m_k2 = m_k1; m_d2 = m_d1;
      m_c1 = cs_n; m_k1 = sck; m_d1 = sdi;
    end
  end

  always @(negedge clk) begin
    if (m_ok && !rst && !finished) begin
      check("R5 octave field vs model", oct, m_word[15:12]);
      check("R5 dac field vs model",    dac, m_word[11:2]);
      check("R5 cnf field vs model",    cnf, m_word[1:0]);
      check("R8 strobe vs model",       upd, m_upd);
      if (upd) upd_cnt++;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic [31:0] data, int nbits);
    cs_n = 1'b0;
    wait_n(HP);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      wait_n(HP);
      sck = 1'b1;
      wait_n(HP);
      sck = 1'b0;
    end
    wait_n(HP);
    cs_n = 1'b1;
    wait_n(10);
  endtask

  task automatic check_word(string req, logic [15:0] w);
    check({req, " octave"}, oct, w[15:12]);
    check({req, " dac"},    dac, w[11:2]);
    check({req, " cnf"},    cnf, w[1:0]);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ew;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    check_word("R1 reset", 16'h0000);
    check("R1 strobe low", upd, 1'b0);

    // R2 R3 full frame
    upd_cnt = 0;
    xfer(32'hA5C3, 16);
    ew = 16'hA5C3;
    check_word("R2 R3 full frame", ew);
    check("R8 two strobes", upd_cnt, 2);

    // R4 truncated 8-bit frame
    upd_cnt = 0;
    xfer(32'h3C, 8);
    ew = {8'h3C, ew[7:0]};
    check_word("R4 upper byte only", ew);
    check("R4 low byte kept cnf", cnf, 2'b11);
    check("R8 one strobe", upd_cnt, 1);

    // R6 abort after five bits
    upd_cnt = 0;
    xfer(32'h15, 5);
    check_word("R6 partial byte dropped", ew);
    check("R6 no strobe", upd_cnt, 0);
    xfer(32'h1234, 16);
    ew = 16'h1234;
    check_word("R6 restart at upper byte", ew);

    // R6 abort mid second byte
    xfer(32'hABC, 12);
    ew = {8'hAB, ew[7:0]};
    check_word("R6 partial second byte", ew);

    // R7 idle toggling
    upd_cnt = 0;
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sck = 1'b1; wait_n(HP); sck = 1'b0; wait_n(HP);
    end
    wait_n(6);
    check_word("R7 idle edges ignored", ew);
    check("R7 no strobe", upd_cnt, 0);

    // R9 over-long frame
    upd_cnt = 0;
    xfer(32'h5A5A7, 20);
    ew = 16'h5A5A;
    check_word("R9 extra bits ignored", ew);
    check("R9 two strobes", upd_cnt, 2);

    // R10 latency of a byte write
    cs_n = 1'b0;
    wait_n(HP);
    for (int i = 0; i < 8; i++) begin
      sdi = (8'hE7 >> (7 - i)) & 1;
      wait_n(HP);
      sck = 1'b1;
      if (i < 7) begin
        wait_n(HP);
        sck = 1'b0;
      end
    end
    wait_n(1);
    check("R10 old after edge one", oct, 4'h5);
    wait_n(1);
    check("R10 old after edge two", oct, 4'h5);
    check("R10 no strobe yet", upd, 1'b0);
    wait_n(1);
    check("R10 new after edge three", oct, 4'hE);
    check("R10 strobe with value", upd, 1'b1);
    wait_n(1);
    check("R8 strobe one cycle", upd, 1'b0);
    sck = 1'b0;
    wait_n(HP);
    cs_n = 1'b1;
    wait_n(10);
    check_word("R10 final word", {8'hE7, 8'h5A});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule